// File: doc/BRIEF.md
# Range to Ternary Prefix Generator

This block takes an inclusive integer window, given as a lower and an upper bound, and turns it into the shortest list of ternary words that together match every integer in the window and nothing outside it. Each word has a value and a mask. A mask bit of 1 marks a don't-care position. The don't-cares always form a run in the low-order bits, so each word stands for an aligned block of 2^k consecutive integers.

A loader writes the words into consecutive entries of a ternary content-addressable memory, one word per clock cycle. The block walks the window from the bottom up. At each step it emits the largest aligned block that starts at the current position and stays inside the window, then moves past that block. When the lower bound is above the upper bound, the window is empty: no word is emitted and completion is signalled at once.

Top module: `rangePrefixGen`

## Requirements
- R1: After reset, `busyOut`, `wordValid` and `doneOut` are all 0.
- R2: A `startIn` high at a clock edge while `busyOut` is 0 captures `lowerIn` and `upperIn` and sets `busyOut` on that edge. The first word (or the empty-window completion) is presented in the cycle that follows, and the first word's value equals the captured lower bound.
- R3: In every valid word, the mask has the form 2^k−1 (its 1 bits are a run starting at bit 0), and every value bit under a mask 1 is 0.
- R4: Words appear on consecutive cycles in ascending order with no gaps. Each word's value is one more than the highest integer covered by the previous word, and the last word covers the upper bound.
- R5: Each word covers the largest aligned block that starts at the current position and does not pass the upper bound, so the list is the minimal greedy cover.
- R6: `doneOut` is high in the same cycle as the last valid word, and `busyOut` is 0 from the following cycle.
- R7: When lower equals upper, exactly one word is emitted, with value equal to the bound and mask 0.
- R8: When lower is greater than upper, `wordValid` stays 0, `doneOut` is high in the cycle after the start, and the block is idle the cycle after that.
- R9: A single window never yields more than 2·WORD_W−2 words.
- R10: `startIn`, `lowerIn` and `upperIn` are ignored while `busyOut` is 1. The list in progress is unaffected by them.
- R11: The window 0 to 2^WORD_W−1 yields a single word with every mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Request to begin a new window, accepted while idle |
| lowerIn | input | WORD_W | Inclusive lower bound |
| upperIn | input | WORD_W | Inclusive upper bound |
| busyOut | output | 1 | High while a window is being expanded |
| wordValid | output | 1 | The word on `wordValue`/`wordMask` is valid this cycle |
| wordValue | output | WORD_W | Value of the current ternary word |
| wordMask | output | WORD_W | Don't-care mask of the current word, 1 = don't-care |
| doneOut | output | 1 | Completion of the current window, with the last word or alone for an empty window |

## Verification
If the running position register is wrong, the next word starts at the wrong value or leaves a gap, and this shows at the ports in the very next valid cycle. A wrong choice of block size shows as a mask that is too wide, so the word runs past the upper bound or is misaligned, or too narrow, so the list is longer than the greedy cover. Either way, the word where it happens differs from the expected one. A control state that is stuck or leaves too early shows as a missing or misplaced `doneOut`, or as `busyOut` still high one cycle after the last word. The sweep covers every pair of bounds, so each of these faults shows up within a few cycles of some start.

// File: rtl/rpgPkg.sv
package rpgPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rpgState_t;

  typedef struct packed {
    logic load;
    logic step;
  } rpgStrobes_t;

endpackage

// File: rtl/rpgBlockSizer.sv
module rpgBlockSizer #(
  parameter int WORD_W = 11
) (
  input  logic [WORD_W:0]   curVal,
  input  logic [WORD_W-1:0] upperVal,
  output logic [WORD_W-1:0] spanMask
);

  logic [WORD_W:0] fitVec;

  // One candidate per block size: aligned at curVal and ending at or below upperVal.
  for (genvar k = 0; k <= WORD_W; k++) begin : g_cand
    localparam logic [WORD_W:0] LOWK = (WORD_W+1)'((64'd1 << k) - 64'd1);
    assign fitVec[k] = ((curVal & LOWK) == '0) &&
                       ((curVal + LOWK) <= {1'b0, upperVal});
  end

  // Both conditions shrink as k grows, so the candidates form a run from k=0.
  always_comb begin
    spanMask = '0;
    for (int i = 0; i <= WORD_W; i++) begin
      if (fitVec[i]) spanMask = WORD_W'((64'd1 << i) - 64'd1);
    end
  end

endmodule

// File: rtl/rpgDatapath.sv
module rpgDatapath
  import rpgPkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  rpgStrobes_t       strobes,
  input  logic [WORD_W-1:0] lowerIn,
  input  logic [WORD_W-1:0] upperIn,
  output logic [WORD_W-1:0] wordValue,
  output logic [WORD_W-1:0] wordMask,
  output logic              emptyRange,
  output logic              lastWord
);

  localparam int EXT_W = WORD_W + 1;

  logic [EXT_W-1:0]  curQ;
  logic [WORD_W-1:0] upQ;
  logic [WORD_W-1:0] spanMask;
  logic [EXT_W-1:0]  blockTop;

  rpgBlockSizer #(.WORD_W(WORD_W)) u_sizer (
    .curVal   (curQ),
    .upperVal (upQ),
    .spanMask (spanMask)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ <= '0;
      upQ  <= '0;
    end else if (strobes.load) begin
      curQ <= {1'b0, lowerIn};
      upQ  <= upperIn;
    end else if (strobes.step) begin
      curQ <= blockTop + EXT_W'(1);
    end
  end

  assign blockTop   = curQ + {1'b0, spanMask};
  assign emptyRange = curQ > {1'b0, upQ};
  assign lastWord   = blockTop == {1'b0, upQ};
  assign wordValue  = curQ[WORD_W-1:0];
  assign wordMask   = spanMask;

  // R3
  aligned_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> ((curQ[WORD_W-1:0] & spanMask) == '0) && ((spanMask & (spanMask + WORD_W'(1))) == '0));

  // R5
  block_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> (blockTop <= {1'b0, upQ}));

  // R10
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> $stable(upQ));

endmodule

// File: rtl/rpgControl.sv
module rpgControl
  import rpgPkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        emptyRange,
  input  logic        lastWord,
  output rpgStrobes_t strobes,
  output logic        busyOut,
  output logic        wordValid,
  output logic        doneOut
);

  localparam int MAX_WORDS = (WORD_W > 1) ? (2 * WORD_W - 2) : 1;
  localparam int CNT_W     = $clog2(MAX_WORDS + 2);

  rpgState_t  stateQ, stateD;
  logic [CNT_W-1:0] wordCount;

  always_comb begin
    stateD    = stateQ;
    strobes   = '0;
    wordValid = 1'b0;
    doneOut   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startIn) begin
          strobes.load = 1'b1;
          stateD       = ST_RUN;
        end
      end
      ST_RUN: begin
        if (emptyRange) begin
          doneOut = 1'b1;
          stateD  = ST_IDLE;
        end else begin
          wordValid    = 1'b1;
          strobes.step = 1'b1;
          if (lastWord) begin
            doneOut = 1'b1;
            stateD  = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordCount <= '0;
    else if (strobes.load) wordCount <= '0;
    else if (strobes.step) wordCount <= wordCount + CNT_W'(1);
  end

  assign busyOut = (stateQ == ST_RUN);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busyOut);

  // R9
  word_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordCount < CNT_W'(MAX_WORDS)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !doneOut) |=> busyOut);

endmodule

// File: rtl/rangePrefixGen.sv
module rangePrefixGen
  import rpgPkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [WORD_W-1:0] lowerIn,
  input  logic [WORD_W-1:0] upperIn,
  output logic              busyOut,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordValue,
  output logic [WORD_W-1:0] wordMask,
  output logic              doneOut
);

  rpgStrobes_t strobes;
  logic        emptyRange;
  logic        lastWord;

  rpgControl #(.WORD_W(WORD_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .emptyRange (emptyRange),
    .lastWord   (lastWord),
    .strobes    (strobes),
    .busyOut    (busyOut),
    .wordValid  (wordValid),
    .doneOut    (doneOut)
  );

  rpgDatapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .lowerIn    (lowerIn),
    .upperIn    (upperIn),
    .wordValue  (wordValue),
    .wordMask   (wordMask),
    .emptyRange (emptyRange),
    .lastWord   (lastWord)
  );

  // R4
  chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(wordValid)) |->
      ({1'b0, wordValue} == $past({1'b0, wordValue} + {1'b0, wordMask}) + (WORD_W+1)'(1)));

  // R6
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid || doneOut) |-> busyOut);

endmodule

// File: tb/rangePrefixGen_tb.sv
module rangePrefixGen_tb;

  localparam int W        = 5;
  localparam int TOP      = (1 << W) - 1;
  localparam int CLK_HALF = 5;
  localparam int MAX_W    = 2 * W - 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [W-1:0] lowerIn = '0;
  logic [W-1:0] upperIn = '0;
  logic         busyOut, wordValid, doneOut;
  logic [W-1:0] wordValue, wordMask;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #CLK_HALF clk = ~clk;

  rangePrefixGen #(.WORD_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lowerIn(lowerIn), .upperIn(upperIn),
    .busyOut(busyOut), .wordValid(wordValid), .wordValue(wordValue),
    .wordMask(wordMask), .doneOut(doneOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Greedy block: largest aligned power of two starting at cur and ending at or below up.
  function automatic int greedyMask(int cur, int up);
    int k = 0;
    while (k < W && (cur % (2 << k)) == 0 && cur + (2 << k) - 1 <= up) k++;
    return (1 << k) - 1;
  endfunction

  task automatic runRange(int lo, int up, bit holdStart);
    int cur = lo;
    int n = 0;
    bit fin = 0;
    string tag;
    @(negedge clk);
    startIn = 1'b1; lowerIn = W'(lo); upperIn = W'(up);
    @(negedge clk);
    if (holdStart) begin
      lowerIn = W'(up); upperIn = W'(lo);
    end else begin
      startIn = 1'b0;
    end
    if (lo > up) begin
      // R8: empty window
      check(!wordValid && doneOut && busyOut, "R8 empty window flags",
            {wordValid, doneOut, busyOut}, 3'b011);
      startIn = 1'b0;
    end else begin
      while (!fin) begin
        int m = greedyMask(cur, up);
        bit expLast = (cur + m == up);
        if (lo == up)                    tag = "R7 single value word";
        else if (lo == 0 && up == TOP)   tag = "R11 full range word";
        else if (holdStart)              tag = "R10 start held while busy";
        else if (n == 0)                 tag = "R2 first word";
        else                             tag = "R4 R5 word sequence";
        check(wordValid, {tag, " valid"}, wordValid, 1);
        check(int'(wordValue) == cur, {tag, " value"}, wordValue, cur);
        check(int'(wordMask) == m, {tag, " R3 mask"}, wordMask, m);
        check(doneOut == expLast, "R6 done with last word", doneOut, expLast);
        cur = cur + m + 1;
        n++;
        if (expLast || !wordValid || n > MAX_W + 2) begin
          fin = 1;
          startIn = 1'b0;
        end else begin
          @(negedge clk);
        end
      end
      check(n <= MAX_W, "R9 word count bound", n, MAX_W);
    end
    @(negedge clk);
    check(!busyOut && !wordValid && !doneOut, "R6 idle after completion",
          {busyOut, wordValid, doneOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held low during reset
    check(!busyOut && !wordValid && !doneOut, "R1 during reset",
          {busyOut, wordValid, doneOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !wordValid && !doneOut, "R1 after reset",
          {busyOut, wordValid, doneOut}, 0);

    runRange(1, TOP, 1'b1);
    runRange(3, 28, 1'b1);
    for (int lo = 0; lo <= TOP; lo++) begin
      for (int up = 0; up <= TOP; up++) begin
        runRange(lo, up, 1'b0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule